// File: doc/BRIEF.md
# UART Receiver with Single-Shot Break Detection

This block is the receive half of a serial port. It watches one asynchronous serial line and samples it on a strobe that runs at sixteen times the bit rate. It rebuilds characters from the line and offers them to software through two readable registers: a receive buffer and a line status word. A character has one start bit, five to eight data bits sent least significant bit first, an optional parity bit, and one or two stop bits. An interrupt request is asserted while a received character or a break is waiting for software.

A break is a low line that lasts longer than a whole frame. The receiver reports each break exactly once. It loads a zero character, sets the break and data-ready flags, and then stays silent until the line has returned high and has stayed high for one full bit time. This means a long break never flags again on later character boundaries. It also means the rising edge at the end of a break cannot be taken as a stray character.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset the status word reads 0x00, the receive buffer reads 0x00 and irq_o is low.
- R2: A frame is decoded with cfg_bits_i = 0..3 meaning 5..8 data bits, sent least significant bit first. A parity bit follows when cfg_par_en_i is 1, and a second stop bit is sampled when cfg_two_stop_i is 1. The character goes to the receive buffer (address 0) with the unused upper bits at zero, and status bit 0 (data ready) is set.
- R3: The start bit is sampled at its 8th oversample. If the line is high there, the event is a glitch and no character is received.
- R4: Reading address 0 clears data ready. irq_o is high whenever data ready (status bit 0) or break (status bit 4) is set.
- R5: A frame whose start, data, parity and stop samples are all low is a break. It sets status bit 4 and bit 0 and loads 0x00 into the receive buffer. A zero character with a high stop bit is a normal character and not a break.
- R6: Reading the status word (address 1) returns {3'b0, break, framing, 1'b0, overrun, ready} and then clears break, framing and overrun.
- R7: While the same break goes on, neither break nor data ready is set again, and irq_o stays low once both have been cleared.
- R8: When the line returns high at the end of a break, no character is received.
- R9: After a break, a new start bit is accepted only after 16 consecutive high oversamples. A frame that starts sooner is ignored.
- R10: A frame that is not all zeros but has a low stop sample sets status bit 3 (framing error) and still delivers its character.
- R11: If a character completes while data ready is still set, status bit 1 (overrun) is set and the new character replaces the buffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick_i | input | 1 | Oversample strobe, 16 per bit time |
| rx_i | input | 1 | Asynchronous serial receive line |
| cfg_bits_i | input | 2 | Data bit count minus five |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_two_stop_i | input | 1 | Two stop bits |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 1 | 0 = receive buffer, 1 = line status |
| rd_data_o | output | 8 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases are the quiet periods. One is a break that is still low after software has already handled it. The other is a line that comes back high for less than a bit and then falls again. In both cases correct behaviour is simply that nothing happens. To test this, the stimulus holds the line low for several character times after the first report has been read, and it watches irq_o on every cycle of that window. It then ends a second break with a short high pulse followed by an all-ones frame, which a receiver without the recovery wait would accept as 0xFF. Each quiet window ends with a status read and a receive buffer read, so that any hidden flag or overwritten buffer shows up at the ports.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKW, S_RECOV
    } rx_state_e;

    localparam int LSR_DR = 0;
    localparam int LSR_OE = 1;
    localparam int LSR_FE = 3;
    localparam int LSR_BI = 4;

    typedef struct packed {
        logic       valid;
        logic       brk;
        logic       fe;
        logic [7:0] data;
    } rx_event_t;
endpackage

// File: rtl/uart_brk_sync.sv
module uart_brk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/uart_brk_deframer.sv
module uart_brk_deframer
    import uart_brk_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      rx_i,
    input  logic [1:0] cfg_bits_i,
    input  logic      cfg_par_en_i,
    input  logic      cfg_two_stop_i,
    output rx_event_t ev_o
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] CNT_MID  = CW'(OSR / 2 - 1);

    typedef struct packed {
        rx_state_e   st;
        logic [CW-1:0] cnt;
        logic [2:0]  bidx;
        logic [7:0]  shreg;
        logic        seen_one;
        logic        stop_low;
        logic        sidx;
    } df_state_t;

    df_state_t s_d, s_q;
    rx_event_t ev;
    logic [2:0] last_bit;
    logic       all_one, any_low;

    always_comb begin
        s_d      = s_q;
        ev       = '0;
        last_bit = 3'd4 + {1'b0, cfg_bits_i};
        all_one  = s_q.seen_one | rx_i;
        any_low  = s_q.stop_low | ~rx_i;
        if (tick_i) begin
            case (s_q.st)
                S_IDLE: begin
                    if (!rx_i) begin
                        s_d.st  = S_START;
                        s_d.cnt = '0;
                    end
                end
                S_START: begin
                    if (s_q.cnt == CNT_MID) begin
                        if (rx_i) begin
                            s_d.st = S_IDLE;
                        end else begin
                            s_d.st       = S_DATA;
                            s_d.cnt      = '0;
                            s_d.bidx     = '0;
                            s_d.shreg    = '0;
                            s_d.seen_one = 1'b0;
                            s_d.stop_low = 1'b0;
                            s_d.sidx     = 1'b0;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (s_q.cnt == CNT_LAST) begin
                        s_d.cnt             = '0;
                        s_d.shreg[s_q.bidx] = rx_i;
                        s_d.seen_one        = all_one;
                        if (s_q.bidx == last_bit)
                            s_d.st = cfg_par_en_i ? S_PAR : S_STOP;
                        else
                            s_d.bidx = s_q.bidx + 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_PAR: begin
                    if (s_q.cnt == CNT_LAST) begin
                        s_d.cnt      = '0;
                        s_d.seen_one = all_one;
                        s_d.st       = S_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_STOP: begin
                    if (s_q.cnt == CNT_LAST) begin
                        s_d.cnt = '0;
                        if (cfg_two_stop_i && !s_q.sidx) begin
                            s_d.sidx     = 1'b1;
                            s_d.seen_one = all_one;
                            s_d.stop_low = any_low;
                        end else begin
                            ev.valid = 1'b1;
                            if (!all_one) begin
                                ev.brk   = 1'b1;
                                s_d.st   = S_BRKW;
                            end else begin
                                ev.fe    = any_low;
                                ev.data  = s_q.shreg;
                                s_d.st   = S_IDLE;
                            end
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_BRKW: begin
                    if (rx_i) begin
                        s_d.st  = S_RECOV;
                        s_d.cnt = '0;
                    end
                end
                S_RECOV: begin
                    if (!rx_i)                   s_d.cnt = '0;
                    else if (s_q.cnt == CNT_LAST) s_d.st  = S_IDLE;
                    else                         s_d.cnt = s_q.cnt + 1'b1;
                end
                default: s_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign ev_o = ev;

    // R7: a reported break is followed by the wait-for-high state, never a fresh hunt
    p_break_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o.brk |=> (s_q.st == S_BRKW));

    // R8: no event while the line is held low or recovering
    p_silent_after_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_BRKW || s_q.st == S_RECOV) |-> !ev_o.valid);

    // R9: recovery ends only after a full high bit time
    p_recover_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_RECOV && !(tick_i && rx_i && s_q.cnt == CNT_LAST))
        |=> (s_q.st != S_IDLE));

    // R5: a break always carries a zero character
    p_break_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o.brk |-> (ev_o.data == 8'h00 && ev_o.valid));
endmodule

// File: rtl/uart_brk_regs.sv
module uart_brk_regs
    import uart_brk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rx_event_t  ev_i,
    input  logic       rd_en_i,
    input  logic       rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       irq_o
);
    typedef struct packed {
        logic [7:0] rbr;
        logic       dr;
        logic       oe;
        logic       fe;
        logic       bi;
        logic [7:0] rdat;
    } reg_state_t;

    reg_state_t r_d, r_q;
    logic [7:0] lsr;
    logic       rbr_rd, lsr_rd;

    always_comb begin
        r_d          = r_q;
        lsr          = '0;
        lsr[LSR_DR]  = r_q.dr;
        lsr[LSR_OE]  = r_q.oe;
        lsr[LSR_FE]  = r_q.fe;
        lsr[LSR_BI]  = r_q.bi;
        rbr_rd       = rd_en_i && !rd_addr_i;
        lsr_rd       = rd_en_i &&  rd_addr_i;
        if (rd_en_i) r_d.rdat = rd_addr_i ? lsr : r_q.rbr;
        if (rbr_rd) r_d.dr = 1'b0;
        if (lsr_rd) begin
            r_d.oe = 1'b0;
            r_d.fe = 1'b0;
            r_d.bi = 1'b0;
        end
        if (ev_i.valid) begin
            r_d.rbr = ev_i.data;
            r_d.dr  = 1'b1;
            r_d.oe  = r_d.oe | (r_q.dr & ~rbr_rd);
            r_d.fe  = r_d.fe | ev_i.fe;
            r_d.bi  = r_d.bi | ev_i.brk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data_o = r_q.rdat;
    assign irq_o     = r_q.dr | r_q.bi;

    // R6: a status read with no new event leaves the sticky error flags clear
    p_lsr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !ev_i.valid) |=> (!r_q.bi && !r_q.fe && !r_q.oe));

    // R4: a buffer read with no new event leaves data ready clear
    p_rbr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rbr_rd && !ev_i.valid) |=> !r_q.dr);

    // R11: a character landing on unread data flags overrun
    p_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i.valid && r_q.dr && !rd_en_i) |=> r_q.oe);

    // R5: a break event raises the request on the next cycle
    p_break_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.brk |=> (irq_o && r_q.bi));
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
    import uart_brk_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick_i,
    input  logic       rx_i,
    input  logic [1:0] cfg_bits_i,
    input  logic       cfg_par_en_i,
    input  logic       cfg_two_stop_i,
    input  logic       rd_en_i,
    input  logic       rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       irq_o
);
    logic      rx_s;
    rx_event_t ev;

    uart_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    uart_brk_deframer #(.OSR(OSR)) u_deframer (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (os_tick_i),
        .rx_i           (rx_s),
        .cfg_bits_i     (cfg_bits_i),
        .cfg_par_en_i   (cfg_par_en_i),
        .cfg_two_stop_i (cfg_two_stop_i),
        .ev_o           (ev)
    );

    uart_brk_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );
endmodule

// File: tb/uart_brk_rx_test.sv
module uart_brk_rx_test;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx = 1'b1;
    logic [1:0] cfg_bits = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct { logic [7:0] lsr; logic [7:0] data; string tag; } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    uart_brk_rx uut (
        .clk(clk), .rst_n(rst_n), .os_tick_i(os_tick), .rx_i(rx),
        .cfg_bits_i(cfg_bits), .cfg_par_en_i(cfg_par_en),
        .cfg_two_stop_i(cfg_two_stop), .rd_en_i(rd_en),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic hold(input logic v, input int bits);
        rx = v;
        repeat (bits * BIT_CLK) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input logic par,
                        input logic stop, input int idle_bits);
        hold(1'b0, 1);
        for (int i = 0; i < nb; i++) hold(d[i], 1);
        if (cfg_par_en) hold(par, 1);
        hold(stop, 1);
        if (cfg_two_stop) hold(1'b1, 1);
        hold(1'b1, idle_bits);
    endtask

    task automatic push_send(input logic [7:0] d, input int nb, input logic stop,
                             input logic [7:0] lsr, input string tag);
        exp_t e;
        e.lsr = lsr; e.data = d; e.tag = tag;
        sb_q.push_back(e);
        send(d, nb, ^d, stop, 2);
    endtask

    task automatic monitor(input int n);
        logic [7:0] l, v;
        for (int k = 0; k < n; k++) begin
            int w = 0;
            exp_t e;
            while (!irq && w < 4000) begin
                @(negedge clk);
                w++;
            end
            rd(1'b1, l);
            rd(1'b0, v);
            @(negedge clk);
            if (sb_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: got %02h expected nothing", v);
            end else begin
                e = sb_q.pop_front();
                check({e.tag, " status"}, l, e.lsr);
                check({e.tag, " data"}, v, e.data);
                check("R4 irq low after buffer read", {7'b0, irq}, 8'h00);
            end
        end
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit seen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd(1'b1, v); check("R1 status", v, 8'h00);
        rd(1'b0, v); check("R1 buffer", v, 8'h00);
        hold(1'b1, 2);

        // R2 and R10 through the scoreboard, several formats
        fork
            begin
                push_send(8'h55, 8, 1'b1, 8'h01, "R2 8N1 55");
                push_send(8'hA3, 8, 1'b1, 8'h01, "R2 8N1 A3");
                push_send(8'h00, 8, 1'b1, 8'h01, "R5 zero char not break");
                push_send(8'h3C, 8, 1'b0, 8'h09, "R10 framing error");
            end
            monitor(4);
        join
        cfg_bits = 2'd0;
        fork
            push_send(8'h15, 5, 1'b1, 8'h01, "R2 5N1 15");
            monitor(1);
        join
        cfg_bits = 2'd2; cfg_par_en = 1'b1;
        fork
            push_send(8'h6B, 7, 1'b1, 8'h01, "R2 7P1 6B");
            monitor(1);
        join
        cfg_bits = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b1;
        fork
            push_send(8'h81, 8, 1'b1, 8'h01, "R2 8N2 81");
            monitor(1);
        join
        cfg_two_stop = 1'b0;

        // R3 short low glitch
        rx = 1'b0;
        repeat (16) @(negedge clk);
        hold(1'b1, 12);
        check("R3 glitch irq", {7'b0, irq}, 8'h00);
        rd(1'b1, v); check("R3 glitch status", v, 8'h00);

        // R5 break detection
        hold(1'b0, 12);
        check("R5 break irq", {7'b0, irq}, 8'h01);
        rd(1'b1, v); check("R5 break status", v, 8'h11);
        rd(1'b0, v); check("R5 break buffer", v, 8'h00);
        @(negedge clk);
        check("R4 irq cleared", {7'b0, irq}, 8'h00);

        // R7 long break stays quiet
        seen = 1'b0;
        for (int i = 0; i < 40 * BIT_CLK; i++) begin
            @(negedge clk);
            if (irq) seen = 1'b1;
        end
        check("R7 no irq during break", {7'b0, seen}, 8'h00);
        rd(1'b1, v); check("R7 status during break", v, 8'h00);

        // R8 end of break
        hold(1'b1, 4);
        check("R8 irq at break end", {7'b0, irq}, 8'h00);
        rd(1'b1, v); check("R8 status at break end", v, 8'h00);
        fork
            push_send(8'h5A, 8, 1'b1, 8'h01, "R8 char after break");
            monitor(1);
        join

        // R9 short recovery then all-ones frame is ignored
        hold(1'b0, 12);
        rd(1'b1, v); check("R9 second break status", v, 8'h11);
        rd(1'b0, v);
        rx = 1'b1;
        repeat (4 * TICK_DIV) @(negedge clk);
        send(8'hFF, 8, 1'b0, 1'b1, 3);
        check("R9 irq after early frame", {7'b0, irq}, 8'h00);
        rd(1'b1, v); check("R9 status after early frame", v, 8'h00);

        // R11 overrun
        send(8'h11, 8, 1'b0, 1'b1, 1);
        send(8'h22, 8, 1'b0, 1'b1, 1);
        rd(1'b1, v); check("R11 overrun status", v, 8'h03);
        rd(1'b0, v); check("R11 newest data", v, 8'h22);
        rd(1'b1, v); check("R6 flags cleared by status read", v, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule